// File: doc/BRIEF.md
# Split-Read Error Character Counter

This block keeps a saturating count of received characters that a pattern comparator has marked as wrong. The count is wider than the management bus, so software reads it as two bus words: the upper word first, then the lower word. Only characters qualified by the valid strobe are counted.

A read of the upper word has two side effects on the same clock edge. It copies the current lower bits of the count into a holding register, and it clears the count. A later read of the lower word returns the holding register, so the two words always describe the same instant. An error that arrives in the cycle of the clear starts the new count at one. Reading the lower word has no side effect, and a lower-word value read without a prior upper-word read is stale.

Top module: `err_char_cnt`

## Requirements
- R1: After reset, the count and the holding register are zero, so both words read as zero.
- R2: Each cycle in which the valid strobe and the error flag are both high adds one to the count.
- R3: A cycle where only one of the valid strobe and the error flag is high leaves the count unchanged.
- R4: With the select at 0 (upper word), the read data shows the count bits above the bus width, zero-extended. This output is combinational and depends on no strobe.
- R5: A read strobe with the select at 0 copies the lower bus-width bits of the count into the holding register. With the select at 1 (lower word), the read data shows the holding register.
- R6: A read strobe with the select at 0 clears the count after the copy. If a qualified error arrives in that same cycle, the count becomes one.
- R7: A read strobe with the select at 1 changes neither the count nor the holding register. A select change without a strobe changes nothing either.
- R8: The count stops at all ones and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_vld_i | input | 1 | A received character is present this cycle |
| char_err_i | input | 1 | The present character failed the pattern compare |
| rd_i | input | 1 | Register read strobe, one cycle per access |
| rd_sel_i | input | 1 | 0 selects the upper word, 1 selects the lower (held) word |
| rd_data_o | output | BUS_W | Read data for the selected word |

## Verification
A wrong holding register shows on the lower-word data right after the next upper-word read. The stimulus reads that word one cycle later, so the fault shows within a cycle. A count that misses a clear or takes a spurious increment shows on the upper word only after a carry reaches it. For that reason the bench runs more than 2^16 errors, and it also checks each small count through the held lower word. Saturation is checked on a narrow instance, where wrap-around would show as a drop in the upper word within one cycle.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } word_sel_e;
endpackage

// File: rtl/err_cnt_core.sv
module err_cnt_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sat;
  assign sat = (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= {{(CNT_W-1){1'b0}}, inc_i};
    else if (inc_i && !sat)     cnt_o <= cnt_o + 1'b1;
  end

  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1);

  // R6
  clr_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == {{(CNT_W-1){1'b0}}, $past(inc_i)});

  // R8
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/err_cnt_snap.sv
module err_cnt_snap #(
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [BUS_W-1:0] d_i,
  output logic [BUS_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end

  // R5
  snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> q_o == $past(d_i));

  // R7
  snap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));
endmodule

// File: rtl/err_char_cnt.sv
module err_char_cnt
  import err_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             char_vld_i,
  input  logic             char_err_i,
  input  logic             rd_i,
  input  logic             rd_sel_i,
  output logic [BUS_W-1:0] rd_data_o
);
  localparam int unsigned HI_W = CNT_W - BUS_W;

  logic [CNT_W-1:0] cnt;
  logic [BUS_W-1:0] hold;
  logic [BUS_W-1:0] hi_word;
  logic             inc;
  logic             rd_hi;
  word_sel_e        sel;

  assign sel   = word_sel_e'(rd_sel_i);
  assign inc   = char_vld_i & char_err_i;
  assign rd_hi = rd_i & (sel == SEL_HI);

  err_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .clr_i (rd_hi),
    .cnt_o (cnt)
  );

  err_cnt_snap #(.BUS_W(BUS_W)) u_snap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (rd_hi),
    .d_i   (cnt[BUS_W-1:0]),
    .q_o   (hold)
  );

  generate
    if (HI_W == BUS_W) begin : g_hi_full
      assign hi_word = cnt[CNT_W-1:BUS_W];
    end else begin : g_hi_pad
      assign hi_word = {{(BUS_W-HI_W){1'b0}}, cnt[CNT_W-1:BUS_W]};
    end
  endgenerate

  assign rd_data_o = (sel == SEL_HI) ? hi_word : hold;

  initial begin
    // R4
    width_fit_chk: assert (CNT_W > BUS_W && CNT_W <= 2 * BUS_W);
  end

  // R7
  lo_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == SEL_LO && !inc) |=> ($stable(cnt) && $stable(hold)));
endmodule

// File: tb/err_char_cnt_tb.sv
module err_char_cnt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, err = 1'b0, rd = 1'b0, sel = 1'b0;
  logic [15:0] dout;
  logic [7:0]  dout_s;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  err_char_cnt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .char_vld_i(vld), .char_err_i(err),
    .rd_i(rd), .rd_sel_i(sel), .rd_data_o(dout)
  );

  err_char_cnt #(.CNT_W(12), .BUS_W(8)) u_dut_sat (
    .clk_i(clk), .rst_ni(rst_n), .char_vld_i(vld), .char_err_i(err),
    .rd_i(rd), .rd_sel_i(sel), .rd_data_o(dout_s)
  );

  // {vld, err, rd, sel, expected read data before the edge}
  localparam logic [19:0] TBL [14] = '{
    {4'b1100, 16'd0},  // R4 hi=0, cnt->1
    {4'b1101, 16'd0},  // R2 lo hold=0, cnt->2
    {4'b1000, 16'd0},  // R3 vld only
    {4'b0100, 16'd0},  // R3 err only
    {4'b0011, 16'd0},  // R7 lo read, no effect
    {4'b0010, 16'd0},  // R5 hi read: hold<=2, cnt<=0
    {4'b0001, 16'd2},  // R5 hold shows 2
    {4'b1111, 16'd2},  // R7 lo read with error, cnt->1
    {4'b1101, 16'd2},  // R7 hold kept, cnt->2
    {4'b1110, 16'd0},  // R6 hi read + error: hold<=2, cnt<=1
    {4'b0010, 16'd0},  // R6 hi read: hold<=1, cnt<=0
    {4'b0001, 16'd1},  // R6 restart counted one
    {4'b0010, 16'd0},  // R6 hi read: hold<=0
    {4'b0001, 16'd0}   // R6 cleared count held 0
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic e, input logic r, input logic s);
    @(negedge clk);
    vld = v; err = e; rd = r; sel = s;
    #1;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    drive(0, 0, 0, 0); chk("R1 hi", dout, 16'd0);
    drive(0, 0, 0, 1); chk("R1 lo", dout, 16'd0);
    rst_n = 1'b1;

    foreach (TBL[i]) begin
      drive(TBL[i][19], TBL[i][18], TBL[i][17], TBL[i][16]);
      chk($sformatf("table[%0d]", i), dout, TBL[i][15:0]);
    end

    // R2 carry into upper word after 65537 errors
    for (int k = 0; k < 65537; k++) drive(1, 1, 0, 0);
    drive(0, 0, 0, 0); chk("R4 carry hi", dout, 16'd1);
    drive(0, 0, 1, 0); chk("R4 hi before clear", dout, 16'd1);
    drive(0, 0, 0, 1); chk("R5 held lo", dout, 16'd1);
    drive(0, 0, 0, 0); chk("R6 hi after clear", dout, 16'd0);

    // R8 saturation on narrow instance: 12-bit count, 8-bit bus
    drive(0, 0, 1, 0);
    for (int k = 0; k < 4200; k++) drive(1, 1, 0, 0);
    drive(0, 0, 0, 0); chk("R8 sat hi", {8'd0, dout_s}, 16'h000F);
    drive(1, 1, 0, 0); chk("R8 sat stays", {8'd0, dout_s}, 16'h000F);
    drive(0, 0, 1, 0); chk("R8 hi read", {8'd0, dout_s}, 16'h000F);
    drive(0, 0, 0, 1); chk("R8 held lo all ones", {8'd0, dout_s}, 16'h00FF);
    drive(0, 0, 0, 0); chk("R8 cleared", {8'd0, dout_s}, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule